// File: doc/BRIEF.md
# Address-Agnostic Exclusive Reservation Monitor

This block sits next to the load/store unit of a single processor and decides whether each store-exclusive succeeds. It keeps one bit of state: the reservation is either open or held. A load-exclusive sets the reservation. The next store-exclusive uses it up, whatever its outcome. Clear-exclusive and exception entry drop it. No address is stored, so the reservation covers all of memory. A store-exclusive after a load-exclusive succeeds even if the two addresses differ. Ordinary stores in between leave the reservation in place.

For each store-exclusive the block returns a registered pass/fail status. It also drives a registered write port toward memory, so a failed store-exclusive never reaches memory. Ordinary stores use the same write port.

Top module: `resv_monitor`

## Requirements
- R1: After reset the reservation is open, `stStatusValid` and `memWe` are 0, and the first store-exclusive fails.
- R2: A load-exclusive sets the reservation. A later store-exclusive then passes: `stStatus`=0, and `memWe`=1 with that store's `addr` and `wdata` on `memAddr`/`memWdata`. Repeated load-exclusives keep the reservation set.
- R3: The store-exclusive address is not compared with the load-exclusive address. A store-exclusive to any address passes while the reservation is set.
- R4: A store-exclusive while the reservation is open returns `stStatus`=1 and leaves `memWe` at 0.
- R5: Every store-exclusive leaves the reservation open, whether it passes or fails. Two store-exclusives after one load-exclusive give status 0, then 1.
- R6: `clrExcl` leaves the reservation open, so the following store-exclusive fails.
- R7: An ordinary store (`stPlain`) writes memory (`memWe`=1 with its address and data one cycle later) and does not disturb the reservation.
- R8: `excEntry` leaves the reservation open.
- R9: When `ldExcl` arrives in the same cycle as `clrExcl` or `excEntry`, the clear wins and the reservation ends up open.
- R10: Status and write outputs are registered. They appear in the cycle after the strobe and last exactly one cycle. `stStatus` is meaningful only while `stStatusValid` is 1.
- R11: An ordinary store in the same cycle as a store-exclusive is ignored. Only a passing store-exclusive writes, and only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ldExcl | input | 1 | Load-exclusive strobe |
| stExcl | input | 1 | Store-exclusive strobe |
| clrExcl | input | 1 | Clear-exclusive strobe |
| stPlain | input | 1 | Ordinary store strobe |
| excEntry | input | 1 | Exception-entry strobe |
| addr | input | ADDR_W | Store address |
| wdata | input | DATA_W | Store data |
| stStatus | output | 1 | Store-exclusive result: 0 pass, 1 fail |
| stStatusValid | output | 1 | `stStatus` is valid this cycle |
| memWe | output | 1 | Write enable toward memory |
| memAddr | output | ADDR_W | Write address toward memory |
| memWdata | output | DATA_W | Write data toward memory |

## Verification
The assertions check the state transitions on every cycle: load sets the reservation, store-exclusive, clear and exception entry drop it, and a clear wins over a load in the same cycle. They also check, every cycle, that a failed status never comes with a write and that the status pulse lasts exactly one cycle after each store-exclusive. Only the bench scenarios can show the end-to-end sequences. These include a pass at a different address, the pass-then-fail pair, a reservation that survives an ordinary store, and the address and data that reach memory.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic {
    MON_OPEN = 1'b0,
    MON_HELD = 1'b1
  } monState_e;

  // control -> datapath strobes for the current cycle
  typedef struct packed {
    logic grant;    // store-exclusive that succeeds
    logic deny;     // store-exclusive that fails
    logic plainWr;  // ordinary store that reaches memory
  } monStrobe_t;
endpackage

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ldExcl,
  input  logic       stExcl,
  input  logic       clrExcl,
  input  logic       stPlain,
  input  logic       excEntry,
  output monStrobe_t strobe,
  output logic       held
);
  monState_e state, stateNext;
  logic dropAll;

  assign dropAll = clrExcl | excEntry;

  always_comb begin
    stateNext = state;
    if (dropAll)     stateNext = MON_OPEN;
    else if (ldExcl) stateNext = MON_HELD;
    else if (stExcl) stateNext = MON_OPEN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MON_OPEN;
    else       state <= stateNext;
  end

  assign held           = (state == MON_HELD);
  assign strobe.grant   = stExcl & held;
  assign strobe.deny    = stExcl & ~held;
  assign strobe.plainWr = stPlain & ~stExcl;

  assert_load_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ldExcl && !dropAll) |=> held);
  assert_stx_drops_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stExcl && !ldExcl && !dropAll) |=> !held);
  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rstN)
    clrExcl |=> !held);
  assert_exc_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
    excEntry |=> !held);
  assert_clear_beats_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ldExcl && dropAll) |=> !held);
  assert_plain_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stPlain && !stExcl && !ldExcl && !dropAll) |=> (held == $past(held)));
endmodule

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  monStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              stStatus,
  output logic              stStatusValid,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  logic doWrite, doReport;

  assign doWrite  = strobe.grant | strobe.plainWr;
  assign doReport = strobe.grant | strobe.deny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stStatus      <= 1'b0;
      stStatusValid <= 1'b0;
      memWe         <= 1'b0;
      memAddr       <= '0;
      memWdata      <= '0;
    end else begin
      stStatusValid <= doReport;
      memWe         <= doWrite;
      if (doReport) stStatus <= strobe.deny;
      if (doWrite) begin
        memAddr  <= addr;
        memWdata <= wdata;
      end
    end
  end

  assert_fail_no_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stStatusValid && stStatus) |-> !memWe);
  assert_pass_writes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stStatusValid && !stStatus) |-> memWe);
  assert_status_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.grant || strobe.deny) |=> !stStatusValid);
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.grant && strobe.deny));
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldExcl,
  input  logic              stExcl,
  input  logic              clrExcl,
  input  logic              stPlain,
  input  logic              excEntry,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              stStatus,
  output logic              stStatusValid,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  monStrobe_t strobe;
  logic       held;

  resv_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .ldExcl(ldExcl), .stExcl(stExcl),
    .clrExcl(clrExcl), .stPlain(stPlain), .excEntry(excEntry),
    .strobe(strobe), .held(held)
  );

  resv_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .wdata(wdata),
    .stStatus(stStatus), .stStatusValid(stStatusValid),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  assert_reservation_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stExcl && held && !clrExcl && !excEntry) |=> (stStatusValid && !stStatus));
endmodule

// File: tb/test_resv_monitor.sv
module test_resv_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldExcl = 0, stExcl = 0, clrExcl = 0, stPlain = 0, excEntry = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic stStatus, stStatusValid, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;

  int nChecks = 0;
  int nFails = 0;
  bit summaryDone = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_monitor #(.ADDR_W(AW), .DATA_W(DW)) i_resv_monitor (
    .clk(clk), .rstN(rstN), .ldExcl(ldExcl), .stExcl(stExcl), .clrExcl(clrExcl),
    .stPlain(stPlain), .excEntry(excEntry), .addr(addr), .wdata(wdata),
    .stStatus(stStatus), .stStatusValid(stStatusValid), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  typedef struct packed {
    logic [23:0]   tag;
    logic          ld, st, clr, pl, ex;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          eV, eS, eW;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{"R4 ", 0,1,0,0,0, 16'h0100, 32'h11, 1,1,0},  // open store-exclusive fails
    '{"R2 ", 1,0,0,0,0, 16'h0200, 32'h00, 0,0,0},
    '{"R3 ", 0,1,0,0,0, 16'h0300, 32'hAA, 1,0,1},  // other address still passes
    '{"R5 ", 0,1,0,0,0, 16'h0300, 32'hBB, 1,1,0},  // second one fails
    '{"R2 ", 1,0,0,0,0, 16'h0200, 32'h00, 0,0,0},
    '{"R7 ", 0,0,0,1,0, 16'h0400, 32'h44, 0,0,1},  // plain store writes
    '{"R7 ", 0,1,0,0,0, 16'h0500, 32'h55, 1,0,1},  // reservation survived
    '{"R2 ", 1,0,0,0,0, 16'h0200, 32'h00, 0,0,0},
    '{"R6 ", 0,0,1,0,0, 16'h0000, 32'h00, 0,0,0},
    '{"R6 ", 0,1,0,0,0, 16'h0600, 32'h66, 1,1,0},
    '{"R2 ", 1,0,0,0,0, 16'h0200, 32'h00, 0,0,0},
    '{"R8 ", 0,0,0,0,1, 16'h0000, 32'h00, 0,0,0},
    '{"R8 ", 0,1,0,0,0, 16'h0610, 32'h67, 1,1,0},
    '{"R9 ", 1,0,1,0,0, 16'h0200, 32'h00, 0,0,0},  // load + clear
    '{"R9 ", 0,1,0,0,0, 16'h0620, 32'h68, 1,1,0},
    '{"R9 ", 1,0,0,0,1, 16'h0200, 32'h00, 0,0,0},  // load + exception
    '{"R9 ", 0,1,0,0,0, 16'h0630, 32'h69, 1,1,0},
    '{"R11", 0,1,0,1,0, 16'h0700, 32'h77, 1,1,0},  // plain ignored, no write
    '{"R2 ", 1,0,0,0,0, 16'h0200, 32'h00, 0,0,0},
    '{"R11", 0,1,0,1,0, 16'h0800, 32'h88, 1,0,1},  // single write
    '{"R10", 0,0,0,0,0, 16'h0000, 32'h00, 0,0,0}   // pulses end
  };

  task automatic drive(input logic ld, st, clr, pl, ex,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    ldExcl = ld; stExcl = st; clrExcl = clr; stPlain = pl; excEntry = ex;
    addr = a; wdata = d;
  endtask

  task automatic checkOut(input logic [23:0] tag, input logic eV, eS, eW,
                          input logic [AW-1:0] eA, input logic [DW-1:0] eD);
    bit ok;
    ok = (stStatusValid === eV) && (!eV || stStatus === eS) && (memWe === eW)
         && (!eW || (memAddr === eA && memWdata === eD));
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got valid=%b status=%b we=%b addr=%h data=%h exp valid=%b status=%b we=%b addr=%h data=%h",
               tag, stStatusValid, stStatus, memWe, memAddr, memWdata, eV, eS, eW, eA, eD);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1 ", 0, 0, 0, '0, '0);           // outputs quiet in reset
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 ", 0, 0, 0, '0, '0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].ld, VECS[i].st, VECS[i].clr, VECS[i].pl, VECS[i].ex,
            VECS[i].a, VECS[i].d);
      @(negedge clk);
      checkOut(VECS[i].tag, VECS[i].eV, VECS[i].eS, VECS[i].eW, VECS[i].a, VECS[i].d);
    end

    // R1: reset while the reservation is held drops it
    drive(1,0,0,0,0, 16'h0200, 0);
    @(negedge clk);
    drive(0,0,0,0,0, 0, 0);
    rstN = 1'b0;
    @(negedge clk);
    checkOut("R1 ", 0, 0, 0, '0, '0);
    rstN = 1'b1;
    drive(0,1,0,0,0, 16'h0900, 32'h99);
    @(negedge clk);
    checkOut("R1 ", 1, 1, 0, '0, '0);

    // R2: repeated loads keep it held, then one pass
    drive(1,0,0,0,0, 16'h0A00, 0);
    @(negedge clk);
    drive(1,0,0,0,0, 16'h0B00, 0);
    @(negedge clk);
    drive(0,1,0,0,0, 16'h0C00, 32'hCAFE0001);
    @(negedge clk);
    checkOut("R2 ", 1, 0, 1, 16'h0C00, 32'hCAFE0001);
    drive(0,0,0,0,0, 0, 0);
    @(negedge clk);
    checkOut("R10", 0, 0, 0, '0, '0);

    finishRun();
  end
endmodule